// File: doc/BRIEF.md
# Bus Target Disconnect and Retry Control

This block sits on the slave side of a bus target. It decides, for each inbound transaction, how the target will end it. The target can let a burst run, stop it with the first data phase, or answer with a retry before any data moves. The choice comes from a four-bit control register and from a flag that says posted data is still waiting to go out in the opposite direction. The same register also holds the enable for the slave write buffer, which is passed straight to an output.

The transaction sequencer pulses `txn_start` in the address cycle and gives the direction with it. It raises `first_data` in the cycle the first data phase completes and raises `frame_end` in the last cycle of the transaction. The block drives `stop_req` and `retry_req` back to the bus interface. Bursts can be limited separately for reads and for writes. The policy is fixed when a transaction starts, so later register writes and later changes of the pending flag affect only the next transaction.

Top module: `tdr_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` is 0 and `stop_req`, `retry_req` and `wbuf_en` are all low.
- R2: When `cfg_we` is high at a clock edge, all four control bits load from `cfg_wdata` together, and `cfg_rdata` shows the new value from the next cycle on. The bits are: bit 0 single-write, bit 1 single-read, bit 2 retry-enable, bit 3 write-buffer enable.
- R3: `wbuf_en` always equals control bit 3.
- R4: On a write that starts with bit 0 set and no retry, `stop_req` is low until the cycle in which `first_data` is high. It is high from that cycle through the `frame_end` cycle and low in the cycle after.
- R5: On a write that starts with bit 0 clear and no retry, `stop_req` stays low for the whole transaction, whatever the value of bit 1.
- R6: On a read, bit 1 plays the role that bit 0 plays on a write, with the same stop timing as R4. Bit 0 has no effect on reads.
- R7: If bit 2 and `outbound_pending` are both high in the `txn_start` cycle, `retry_req` and `stop_req` are high from the next cycle through the `frame_end` cycle, whatever the direction and bits 0 and 1.
- R8: No retry is given when bit 2 or `outbound_pending` is low in the `txn_start` cycle. A change of `outbound_pending` after the start has no effect on the transaction.
- R9: A register write made during a transaction does not change how that transaction is handled.
- R10: While no transaction is in progress, `stop_req` and `retry_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control register write value |
| cfg_rdata | output | 4 | Current control register value |
| txn_start | input | 1 | Address cycle of a new inbound transaction |
| txn_write | input | 1 | Direction, 1 = write, sampled with `txn_start` |
| first_data | input | 1 | First data phase completes this cycle |
| frame_end | input | 1 | Last cycle of the current transaction |
| outbound_pending | input | 1 | Posted data waiting to go outbound |
| stop_req | output | 1 | Stop or disconnect request to the bus |
| retry_req | output | 1 | Retry request (no data transferred) |
| wbuf_en | output | 1 | Slave write buffer enable |

## Verification
The assertions take three things about the inputs for granted. `txn_start` arrives only when no transaction is open. Every transaction ends with exactly one `frame_end`. `first_data` is never raised while a retry is being signalled, because a target that retries moves no data. The bench's transaction task produces only such sequences. It always ends each transaction with one idle cycle before the next start, and on retried transactions it sends only the closing cycle. The stimulus deliberately changes `outbound_pending` and writes the register in the middle of transactions, so that the policy is shown to be fixed at the start.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int CTRL_W = 4;

    typedef struct packed {
        logic wbuf;
        logic retry_en;
        logic single_rd;
        logic single_wr;
    } ctrl_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BURST = 2'd1,
        PH_DISC  = 2'd2,
        PH_RETRY = 2'd3
    } phase_t;

    // Policy for a new transaction: retry wins over disconnect.
    function automatic phase_t pick_phase(ctrl_t c, logic wr, logic pend);
        phase_t p;
        if (c.retry_en && pend)
            p = PH_RETRY;
        else if (wr ? c.single_wr : c.single_rd)
            p = PH_DISC;
        else
            p = PH_BURST;
        return p;
    endfunction

endpackage

// File: rtl/tdr_cfg_reg.sv
module tdr_cfg_reg
    import tdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (we)
            ctrl <= ctrl_t'(wdata);
    end
endmodule

// File: rtl/tdr_policy.sv
module tdr_policy
    import tdr_pkg::*;
(
    input  ctrl_t  ctrl,
    input  logic   wr,
    input  logic   pend,
    output phase_t phase
);
    always_comb phase = pick_phase(ctrl, wr, pend);
endmodule

// File: rtl/tdr_txn_fsm.sv
module tdr_txn_fsm
    import tdr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  phase_t next_phase,
    input  logic   first_data,
    input  logic   frame_end,
    output logic   stop_req,
    output logic   retry_req
);
    phase_t phase;
    logic   data_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            data_seen <= 1'b0;
        end else if (phase == PH_IDLE) begin
            data_seen <= 1'b0;
            if (start)
                phase <= next_phase;
        end else begin
            if (first_data)
                data_seen <= 1'b1;
            if (frame_end) begin
                phase     <= PH_IDLE;
                data_seen <= 1'b0;
            end
        end
    end

    always_comb begin
        retry_req = (phase == PH_RETRY);
        stop_req  = retry_req ||
                    ((phase == PH_DISC) && (first_data || data_seen));
    end
endmodule

// File: rtl/tdr_ctrl.sv
module tdr_ctrl
    import tdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              txn_start,
    input  logic              txn_write,
    input  logic              first_data,
    input  logic              frame_end,
    input  logic              outbound_pending,
    output logic              stop_req,
    output logic              retry_req,
    output logic              wbuf_en
);
    ctrl_t  ctrl;
    phase_t next_phase;

    tdr_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctrl  (ctrl)
    );

    tdr_policy u_pol (
        .ctrl  (ctrl),
        .wr    (txn_write),
        .pend  (outbound_pending),
        .phase (next_phase)
    );

    tdr_txn_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (txn_start),
        .next_phase (next_phase),
        .first_data (first_data),
        .frame_end  (frame_end),
        .stop_req   (stop_req),
        .retry_req  (retry_req)
    );

    assign cfg_rdata = CTRL_W'(ctrl);
    assign wbuf_en   = ctrl.wbuf;
endmodule

// File: rtl/tdr_chk.sv
module tdr_chk
    import tdr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CTRL_W-1:0] cfg_wdata,
    input logic [CTRL_W-1:0] cfg_rdata,
    input logic              txn_start,
    input logic              txn_write,
    input logic              frame_end,
    input logic              outbound_pending,
    input logic              stop_req,
    input logic              retry_req,
    input logic              wbuf_en
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!retry_req && cfg_rdata == '0));

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    // R3
    wbuf_follow_chk: assert property (@(posedge clk) disable iff (rst) wbuf_en == cfg_rdata[3]);

    // R4
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_req && frame_end) |=> !stop_req);

    // R5
    burst_write_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_start && txn_write && !cfg_rdata[0] && !(cfg_rdata[2] && outbound_pending))
        |=> !stop_req);

    // R7
    retry_start_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_start && cfg_rdata[2] && outbound_pending) |=> (retry_req && stop_req));

    // R7
    retry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (retry_req && !frame_end) |=> retry_req);

    // R8
    no_retry_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_start && !(cfg_rdata[2] && outbound_pending)) |=> !retry_req);
endmodule

bind tdr_ctrl tdr_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .cfg_we           (cfg_we),
    .cfg_wdata        (cfg_wdata),
    .cfg_rdata        (cfg_rdata),
    .txn_start        (txn_start),
    .txn_write        (txn_write),
    .frame_end        (frame_end),
    .outbound_pending (outbound_pending),
    .stop_req         (stop_req),
    .retry_req        (retry_req),
    .wbuf_en          (wbuf_en)
);

// File: tb/sim_tdr_ctrl.sv
module sim_tdr_ctrl;
    import tdr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [CTRL_W-1:0] cfg_wdata = '0;
    logic [CTRL_W-1:0] cfg_rdata;
    logic              txn_start = 1'b0;
    logic              txn_write = 1'b0;
    logic              first_data = 1'b0;
    logic              frame_end = 1'b0;
    logic              outbound_pending = 1'b0;
    logic              stop_req, retry_req, wbuf_en;

    always #5 clk = ~clk;

    tdr_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .txn_start(txn_start), .txn_write(txn_write),
        .first_data(first_data), .frame_end(frame_end),
        .outbound_pending(outbound_pending), .stop_req(stop_req),
        .retry_req(retry_req), .wbuf_en(wbuf_en)
    );

    typedef struct {
        logic       stop;
        logic       retry;
        logic [3:0] rdata;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    logic [3:0] mdl = 4'h0;
    bit         done = 1'b0;

    // Monitor: compare one expected item per cycle, away from the edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (stop_req !== e.stop || retry_req !== e.retry ||
                cfg_rdata !== e.rdata || wbuf_en !== e.rdata[3]) begin
                errors++;
                $display("FAIL %s: stop/retry/rdata/wbuf got %b/%b/%h/%b exp %b/%b/%h/%b",
                         e.tag, stop_req, retry_req, cfg_rdata, wbuf_en,
                         e.stop, e.retry, e.rdata, e.rdata[3]);
            end
        end
    end

    // Driver: one cycle of stimulus plus its expected outputs.
    task automatic cyc(input bit st, input bit wr, input bit pend, input bit fd,
                       input bit fe, input bit we, input logic [3:0] wd,
                       input bit es, input bit er, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        txn_start = st; txn_write = wr; outbound_pending = pend;
        first_data = fd; frame_end = fe; cfg_we = we; cfg_wdata = wd;
        e.stop = es; e.retry = er; e.rdata = mdl; e.tag = tag;
        sb.push_back(e);
        if (we) mdl = wd;
    endtask

    task automatic set_cfg(input logic [3:0] v);
        cyc(0, 0, 0, 0, 0, 1, v, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, "R3");
    endtask

    // One transaction; policy from the model register at the start cycle.
    task automatic txn(input bit wr, input bit pend, input int gap, input int beats,
                       input bit midw, input logic [3:0] midv, input string tag);
        bit rty, disc, wrote;
        rty   = mdl[2] && pend;
        disc  = wr ? mdl[0] : mdl[1];
        wrote = 1'b0;
        cyc(1, wr, pend, 0, 0, 0, 4'h0, 0, 0, "R10");
        if (rty) begin
            cyc(0, wr, !pend, 0, 1, 0, 4'h0, 1, 1, tag);
        end else begin
            for (int g = 0; g < gap; g++) begin
                cyc(0, wr, !pend, 0, 0, midw && !wrote, midv, 0, 0, tag);
                wrote = 1'b1;
            end
            for (int b = 0; b < beats; b++) begin
                cyc(0, wr, !pend, b == 0, b == beats - 1, midw && !wrote, midv,
                    disc, 0, tag);
                wrote = 1'b1;
            end
        end
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, "R1");
        set_cfg(4'h1);
        txn(1, 0, 0, 3, 0, 4'h0, "R4");
        txn(0, 0, 0, 3, 0, 4'h0, "R6");
        txn(1, 0, 0, 1, 0, 4'h0, "R4");
        set_cfg(4'h2);
        txn(0, 0, 2, 3, 0, 4'h0, "R6");
        txn(1, 0, 1, 3, 0, 4'h0, "R5");
        set_cfg(4'h0);
        txn(1, 1, 0, 4, 0, 4'h0, "R5");
        set_cfg(4'hC);
        txn(1, 1, 0, 3, 0, 4'h0, "R7");
        txn(0, 0, 0, 3, 0, 4'h0, "R8");
        set_cfg(4'h7);
        txn(0, 1, 0, 3, 0, 4'h0, "R7");
        txn(1, 0, 1, 2, 0, 4'h0, "R8");
        set_cfg(4'h3);
        txn(1, 1, 0, 2, 0, 4'h0, "R8");
        set_cfg(4'h0);
        txn(0, 0, 0, 3, 1, 4'h2, "R9");
        txn(0, 0, 0, 2, 0, 4'h0, "R6");
        set_cfg(4'h8);
        txn(1, 1, 0, 2, 1, 4'h5, "R9");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule